// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block keeps the opening four instruction words of recently taken branch targets. When the fetch unit takes a branch, it presents the target address for one cycle. If the target is cached, the block raises a one-cycle hit flag and plays the four stored words out in order, one per cycle. These words fill the gap while the normal instruction fetch to the target waits on memory. If the target is not cached, the block claims an entry. It then records the first four words that memory returns for that target, so that the next branch to the same address hits.

Storage is two-way set associative with 16 sets. Each entry holds a tag, a valid bit and four words. Each set has a single recency bit that picks the way to replace. A new branch arriving before a fill has finished abandons that fill, and a flush input empties the whole cache in one cycle.

Top module: `btic`

## Requirements
- R1: After reset, hit and out_valid are low and every entry is empty, so the first branch to any target is a miss.
- R2: A lookup takes place only in a cycle with br_valid high. The set is br_target[5:2], the tag is br_target[31:6], and targets are word aligned (br_target[1:0] = 0). hit is high for exactly the one cycle after the branch cycle, and only when the target matches a valid entry.
- R3: On a hit, out_valid is high for four consecutive cycles, starting in the cycle hit is high. out_data carries stored words 0, 1, 2, 3 in that order, and out_valid then falls.
- R4: On a miss, out_valid stays low and the replacement way of the set is made invalid and given the new tag. The next four cycles with mem_valid high write mem_data into words 0 to 3 in order. The entry becomes valid only after the fourth word.
- R5: mem_valid while no fill is open has no effect on any stored word.
- R6: Two targets with the same set index and different tags are held at the same time, and both hit.
- R7: Each set has one recency bit. A hit and a completed fill each mark the way they used as most recent, and a miss replaces the other way.
- R8: A branch arriving while a fill is open ends that fill. The partly written entry stays invalid, so a later branch to its target misses.
- R9: A branch arriving while a hit stream is still running is looked up at once. On a hit, it restarts the stream at word 0 of the new target. On a miss, it stops the stream.
- R10: flush empties every entry in one cycle and ends any open fill and running stream. It takes priority over a branch in the same cycle, which is then not looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole cache |
| br_valid | input | 1 | A branch is taken this cycle |
| br_target | input | ADDR_W | Branch target address |
| mem_valid | input | 1 | Memory returns one target word this cycle |
| mem_data | input | DATA_W | Word returned by memory |
| hit | output | 1 | Lookup of the previous cycle hit |
| out_valid | output | 1 | out_data carries a cached word |
| out_data | output | DATA_W | Cached word, in stream order |

## Verification
The bench builds the block with its default values: 32-bit addresses and words, 16 sets, and four words per entry. Random branch targets are drawn from four tags in each of three sets. With more tags than ways, evictions occur often, and the recency bit decides the outcome of most lookups. Fills are frequently cut short by a new branch or by a flush, and stray memory words arrive while no fill is open. Together these reach the aborted-fill, restarted-stream and flush-priority orderings alongside ordinary hits and misses.

// File: rtl/btic.sv
`timescale 1ns/1ps
module btic #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              hit,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int CNT_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [SETS-1:0]   vld [2];
  logic [SETS-1:0]   lru;
  logic [TAG_W-1:0]  tags [2][SETS];
  logic [DATA_W-1:0] dat  [2][SETS][WORDS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag_in;
  logic [1:0]       way_hit;
  logic             hit_any, hit_way, victim;

  logic             hit_q;
  logic             s_act, s_way;
  logic [IDX_W-1:0] s_set;
  logic [CNT_W-1:0] s_cnt;
  logic             f_act, f_way;
  logic [IDX_W-1:0] f_set;
  logic [CNT_W-1:0] f_cnt;

  assign idx    = br_target[IDX_W+1:2];
  assign tag_in = br_target[ADDR_W-1:IDX_W+2];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = vld[w][idx] && (tags[w][idx] == tag_in);
  end

  assign hit_any = |way_hit;
  assign hit_way = way_hit[1];
  assign victim  = lru[idx];

  logic do_alloc, fill_wr;
  assign do_alloc = br_valid && !flush && !hit_any;
  assign fill_wr  = f_act && mem_valid && !br_valid && !flush;

  assign hit       = hit_q;
  assign out_valid = s_act;
  assign out_data  = dat[s_way][s_set][s_cnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= '0;
      vld[1] <= '0;
      lru    <= '0;
      hit_q  <= 1'b0;
      s_act  <= 1'b0;
      s_way  <= 1'b0;
      s_set  <= '0;
      s_cnt  <= '0;
      f_act  <= 1'b0;
      f_way  <= 1'b0;
      f_set  <= '0;
      f_cnt  <= '0;
    end else if (flush) begin
      vld[0] <= '0;
      vld[1] <= '0;
      hit_q  <= 1'b0;
      s_act  <= 1'b0;
      f_act  <= 1'b0;
    end else if (br_valid) begin
      hit_q <= hit_any;
      if (hit_any) begin
        s_act    <= 1'b1;
        s_way    <= hit_way;
        s_set    <= idx;
        s_cnt    <= '0;
        lru[idx] <= ~hit_way;
        f_act    <= 1'b0;
      end else begin
        s_act            <= 1'b0;
        f_act            <= 1'b1;
        f_way            <= victim;
        f_set            <= idx;
        f_cnt            <= '0;
        vld[victim][idx] <= 1'b0;
      end
    end else begin
      hit_q <= 1'b0;
      if (s_act) begin
        if (s_cnt == LAST) s_act <= 1'b0;
        else               s_cnt <= s_cnt + 1'b1;
      end
      if (fill_wr) begin
        f_cnt <= f_cnt + 1'b1;
        if (f_cnt == LAST) begin
          f_act             <= 1'b0;
          vld[f_way][f_set] <= 1'b1;
          lru[f_set]        <= ~f_way;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) tags[victim][idx] <= tag_in;
    if (fill_wr)  dat[f_way][f_set][f_cnt] <= mem_data;
  end

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> br_target[1:0] == 2'b00);

  p_hit_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(br_valid && !flush));

  p_hit_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> out_valid);

  p_stream_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hit) |-> $past(out_valid));

  p_stream_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s_cnt == LAST && !br_valid && !flush) |=> !out_valid);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_act && br_valid && !flush) |=> !vld[$past(f_way)][$past(f_set)]);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld[0] == '0 && vld[1] == '0 && !hit && !out_valid));
endmodule

// File: tb/tb_btic.sv
`timescale 1ns/1ps
module tb_btic;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_target = '0;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic        hit, out_valid;
  logic [31:0] out_data;

  btic dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .br_valid(br_valid), .br_target(br_target),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .hit(hit), .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  bit          m_vld [2][16];
  logic [25:0] m_tag [2][16];
  logic [31:0] m_dat [2][16][4];
  bit          m_lru [16];
  bit          m_fact;
  int          m_fway, m_fset, m_fcnt;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tsel, input int set);
    logic [25:0] t;
    t = 26'(tsel) * 26'h0A5 + 26'h11;
    return {t, 4'(set), 2'b00};
  endfunction

  function automatic int model_lookup(input logic [31:0] a);
    int s;
    s = int'(a[5:2]);
    for (int w = 0; w < 2; w++)
      if (m_vld[w][s] && m_tag[w][s] == a[31:6]) return w;
    return -1;
  endfunction

  task automatic do_branch(input logic [31:0] a, input int nchk, input string req);
    int s;
    int hw;
    int v;
    s = int'(a[5:2]);
    m_fact = 1'b0;
    hw = model_lookup(a);
    if (hw >= 0) begin
      m_lru[s] = (hw == 0);
    end else begin
      v = int'(m_lru[s]);
      m_vld[v][s] = 1'b0;
      m_tag[v][s] = a[31:6];
      m_fact = 1'b1;
      m_fway = v;
      m_fset = s;
      m_fcnt = 0;
    end
    br_valid = 1'b1;
    br_target = a;
    @(negedge clk);
    br_valid = 1'b0;
    chk(hit == (hw >= 0), req, 32'(hit), 32'(hw >= 0));
    if (hw >= 0) begin
      for (int k = 0; k < nchk; k++) begin
        if (k > 0) @(negedge clk);
        chk(out_valid && out_data == m_dat[hw][s][k], "R3 stream word", out_data, m_dat[hw][s][k]);
      end
      if (nchk == 4) begin
        @(negedge clk);
        chk(!out_valid, "R3 stream ends after four", 32'(out_valid), 32'd0);
      end
    end else begin
      chk(!out_valid, "R4 no stream on miss", 32'(out_valid), 32'd0);
    end
  endtask

  task automatic do_mem(input logic [31:0] d);
    mem_valid = 1'b1;
    mem_data = d;
    if (m_fact) begin
      m_dat[m_fway][m_fset][m_fcnt] = d;
      m_fcnt++;
      if (m_fcnt == 4) begin
        m_vld[m_fway][m_fset] = 1'b1;
        m_lru[m_fset] = (m_fway == 0);
        m_fact = 1'b0;
      end
    end
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  task automatic fill4();
    for (int k = 0; k < 4; k++) do_mem($urandom);
  endtask

  task automatic do_flush(input bit with_br, input logic [31:0] a);
    flush = 1'b1;
    br_valid = with_br;
    br_target = a;
    @(negedge clk);
    flush = 1'b0;
    br_valid = 1'b0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 16; s++) m_vld[w][s] = 1'b0;
    m_fact = 1'b0;
    chk(!hit, "R10 no hit after flush", 32'(hit), 32'd0);
    chk(!out_valid, "R10 no stream after flush", 32'(out_valid), 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b, c, d, h, j, k;
    void'($urandom(32'd2024));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 16; s++) m_vld[w][s] = 1'b0;
    for (int s = 0; s < 16; s++) m_lru[s] = 1'b0;
    m_fact = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hit, "R1 reset hit", 32'(hit), 32'd0);
    chk(!out_valid, "R1 reset stream", 32'(out_valid), 32'd0);

    a = mk(1, 3); b = mk(2, 3); c = mk(3, 3);
    do_branch(a, 4, "R1 first branch misses");
    fill4();
    do_branch(a, 4, "R4 hit after fill");
    do_mem(32'hDEAD_BEEF);
    do_mem(32'h1234_5678);
    do_branch(a, 4, "R5 stray words ignored");

    do_branch(b, 4, "R6 second tag misses");
    fill4();
    do_branch(a, 4, "R6 first tag kept");
    do_branch(b, 4, "R6 second tag kept");

    do_branch(c, 4, "R7 third tag misses");
    fill4();
    do_branch(b, 4, "R7 recent way kept");
    do_branch(a, 4, "R7 older way replaced");

    d = mk(5, 9);
    do_branch(d, 4, "R8 target misses");
    do_mem($urandom);
    do_mem($urandom);
    do_branch(c, 4, "R8 aborting branch");
    do_branch(d, 4, "R8 aborted entry invalid");
    do_branch(c, 4, "R8 abort of second fill");

    h = mk(0, 12); j = mk(1, 13);
    do_branch(h, 4, "R9 setup"); fill4();
    do_branch(j, 4, "R9 setup"); fill4();
    do_branch(h, 2, "R9 first stream");
    do_branch(j, 4, "R9 restarted stream");

    do_flush(1'b0, '0);
    do_branch(j, 4, "R10 miss after flush");
    fill4();
    do_branch(j, 4, "R10 refilled");
    k = j;
    do_flush(1'b1, k);
    do_branch(k, 4, "R10 branch under flush not filled");

    for (int i = 0; i < 2500; i++) begin
      int r;
      int sets [3];
      logic [31:0] t;
      sets = '{2, 6, 10};
      t = mk($urandom_range(0, 3), sets[$urandom_range(0, 2)]);
      r = $urandom_range(0, 99);
      if (r < 60) begin
        do_branch(t, ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : 4, "R2 random lookup");
        if (m_fact) begin
          int nw;
          nw = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : 4;
          for (int q = 0; q < nw; q++) do_mem($urandom);
        end
      end else if (r < 95) begin
        do_mem($urandom);
      end else begin
        do_flush(1'($urandom_range(0, 1)), t);
      end
    end

    summary();
    $finish;
  end
endmodule